// File: doc/BRIEF.md
# Fracturable Six-Input Lookup Table

This block computes any Boolean function of six inputs. The function is held as a 64-entry truth table and read out through a tree of 2:1 multiplexers. A table bit is chosen by the input vector, and the lowest input steers the first stage of the tree.

The block can also run in a split mode. Two mode bits can each tie one of the two upper inputs high before the tree sees it. Separately, two of the four sixteen-entry sub-tables found at the fourth stage of the tree are always brought out as their own outputs. Each of these is a four-input function of the low inputs.

The table and the mode bits sit in one serial shift chain. The chain shifts while its enable is high and holds its contents otherwise. Its last bit is brought out so that several blocks can be chained. Reading the table needs no clock, because it depends only on the stored configuration and the inputs.

Top module: `frac_lut6`

## Requirements
- R1: After reset, all 66 configuration bits are 0, so `lut_out`, `frac_out` and `cfg_out` all read 0.
- R2: Each clock edge with `cfg_en` high moves the chain by one place. A bit entered on `cfg_in` appears on `cfg_out` after 66 enabled edges.
- R3: While `cfg_en` is low, `cfg_in` has no effect and the stored table and mode bits do not change.
- R4: The chain is loaded as 66 bits, first bit first. The order is table bit 63 down to table bit 0, then mode bit 1, then mode bit 0.
- R5: With both mode bits 0, `lut_out` equals table bit {in[5],in[4],in[3],in[2],in[1],in[0]}, with in[5] as the most significant index bit.
- R6: Mode bit 0 forces in[4] to 1 and mode bit 1 forces in[5] to 1. Each acts alone: with only one bit set, the other upper input still selects normally.
- R7: With both mode bits set, `lut_out` equals table bit 48 + in[3:0] (the fourth sub-table), and in[5:4] have no effect.
- R8: `frac_out[0]` equals table bit in[3:0] (sub-table 0, bits 15..0). `frac_out[1]` equals table bit 32 + in[3:0] (sub-table 2). This holds in every mode, and in[5:4] do not affect either output.
- R9: The inputs in[3:0] are never forced. Each of them selects normally in all four mode settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Active-low asynchronous reset; clears the chain |
| cfg_en | input | 1 | Shift enable for the chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Last chain bit, for cascading |
| lut_in | input | 6 | Logic inputs |
| lut_out | output | 1 | Full six-input function |
| frac_out | output | 2 | Exported four-input sub-table outputs |

## Verification
Every table is swept over all 64 input combinations, which reads each of its bits once. The tables are chosen to tell faults apart:
- Tables that repeat the value of one input (in0, in4 or in5) expose a swapped or misrouted select line.
- A table with only its two end bits set exposes an off-by-one in indexing.
- Irregular constants and random tables catch faults in the tap wiring.

These tables are run in each of the four mode settings. This separates forcing of in[4] from forcing of in[5], and checks that the exported taps ignore the mode. Directed tests cover the reset state, the shift order and cascade output after exactly 66 shifts, and a disabled chain with `cfg_in` toggling.

// File: rtl/frac_lut6_pkg.sv
package frac_lut6_pkg;

    typedef enum logic [1:0] {
        GATE_PASS  = 2'b00,
        GATE_HIGH  = 2'b01,
        GATE_LOW   = 2'b10
    } gate_kind_e;

    function automatic int count_forced(input logic [11:0] map, input int k);
        int n;
        n = 0;
        for (int i = 0; i < k; i++) begin
            if (map[2*i +: 2] != GATE_PASS) n++;
        end
        return n;
    endfunction

    function automatic int mode_slot(input logic [11:0] map, input int pos);
        int n;
        n = 0;
        for (int i = 0; i < pos; i++) begin
            if (map[2*i +: 2] != GATE_PASS) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/flut_cfg_chain.sv
module flut_cfg_chain #(
    parameter int TABLE_W = 64,
    parameter int MODE_W  = 2,
    localparam int CHAIN_W = TABLE_W + MODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               shift_in,
    output logic               shift_out,
    output logic [TABLE_W-1:0] table_bits,
    output logic [MODE_W-1:0]  mode_bits
);

    typedef struct packed {
        logic [CHAIN_W-1:0] sr;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.sr = {st_q.sr[CHAIN_W-2:0], shift_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_out  = st_q.sr[CHAIN_W-1];
    assign table_bits = st_q.sr[CHAIN_W-1:MODE_W];
    assign mode_bits  = st_q.sr[MODE_W-1:0];

endmodule

// File: rtl/flut_in_gate.sv
module flut_in_gate
    import frac_lut6_pkg::*;
#(
    parameter int          K         = 6,
    parameter logic [11:0] FORCE_MAP = 12'b01_01_00_00_00_00,
    localparam int         MODE_W    = count_forced(FORCE_MAP, K)
) (
    input  logic [K-1:0]      raw_in,
    input  logic [MODE_W-1:0] mode_bits,
    output logic [K-1:0]      sel_out
);

    for (genvar i = 0; i < K; i++) begin : g_gate
        localparam logic [1:0] KIND = FORCE_MAP[2*i +: 2];
        localparam int         SLOT = mode_slot(FORCE_MAP, i);
        if (KIND == GATE_HIGH) begin : g_or
            assign sel_out[i] = raw_in[i] | mode_bits[SLOT];
        end else if (KIND == GATE_LOW) begin : g_and
            assign sel_out[i] = raw_in[i] & ~mode_bits[SLOT];
        end else begin : g_pass
            assign sel_out[i] = raw_in[i];
        end
    end

endmodule

// File: rtl/flut_mux_tree.sv
module flut_mux_tree #(
    parameter int K       = 6,
    parameter int TAP_LVL = 4,
    localparam int TABLE_W = 1 << K,
    localparam int TAP_N   = TABLE_W >> TAP_LVL
) (
    input  logic [TABLE_W-1:0] table_bits,
    input  logic [K-1:0]       sel,
    output logic               full_out,
    output logic [TAP_N-1:0]   taps
);

    for (genvar s = 0; s <= K; s++) begin : g_lvl
        localparam int N = TABLE_W >> s;
        logic [N-1:0] node;
        if (s == 0) begin : g_leaf
            assign node = table_bits;
        end else begin : g_stage
            for (genvar j = 0; j < N; j++) begin : g_mux
                assign node[j] = sel[s-1] ? g_lvl[s-1].node[2*j+1]
                                          : g_lvl[s-1].node[2*j];
            end
        end
    end

    assign full_out = g_lvl[K].node[0];
    assign taps     = g_lvl[TAP_LVL].node;

endmodule

// File: rtl/flut_tap_sel.sv
module flut_tap_sel #(
    parameter int TAP_N  = 4,
    parameter int FRAC_W = 2,
    parameter int TAP_MASK [FRAC_W] = '{0, 2}
) (
    input  logic [TAP_N-1:0]  taps,
    output logic [FRAC_W-1:0] frac
);

    for (genvar i = 0; i < FRAC_W; i++) begin : g_pick
        assign frac[i] = taps[TAP_MASK[i]];
    end

endmodule

// File: rtl/frac_lut6.sv
module frac_lut6
    import frac_lut6_pkg::*;
#(
    parameter int          K         = 6,
    parameter int          TAP_LVL   = 4,
    parameter logic [11:0] FORCE_MAP = 12'b01_01_00_00_00_00,
    parameter int          FRAC_W    = 2,
    parameter int          TAP_MASK [FRAC_W] = '{0, 2},
    localparam int         TABLE_W   = 1 << K,
    localparam int         MODE_W    = count_forced(FORCE_MAP, K),
    localparam int         TAP_N     = TABLE_W >> TAP_LVL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_in,
    output logic              cfg_out,
    input  logic [K-1:0]      lut_in,
    output logic              lut_out,
    output logic [FRAC_W-1:0] frac_out
);

    logic [TABLE_W-1:0] table_q;
    logic [MODE_W-1:0]  mode_q;
    logic [K-1:0]       sel;
    logic [TAP_N-1:0]   taps;

    flut_cfg_chain #(
        .TABLE_W (TABLE_W),
        .MODE_W  (MODE_W)
    ) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (cfg_en),
        .shift_in   (cfg_in),
        .shift_out  (cfg_out),
        .table_bits (table_q),
        .mode_bits  (mode_q)
    );

    flut_in_gate #(
        .K         (K),
        .FORCE_MAP (FORCE_MAP)
    ) u_gate (
        .raw_in    (lut_in),
        .mode_bits (mode_q),
        .sel_out   (sel)
    );

    flut_mux_tree #(
        .K       (K),
        .TAP_LVL (TAP_LVL)
    ) u_tree (
        .table_bits (table_q),
        .sel        (sel),
        .full_out   (lut_out),
        .taps       (taps)
    );

    flut_tap_sel #(
        .TAP_N    (TAP_N),
        .FRAC_W   (FRAC_W),
        .TAP_MASK (TAP_MASK)
    ) u_pick (
        .taps (taps),
        .frac (frac_out)
    );

endmodule

// File: rtl/frac_lut6_chk.sv
module frac_lut6_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_en,
    input logic        cfg_in,
    input logic        cfg_out,
    input logic [5:0]  lut_in,
    input logic        lut_out,
    input logic [1:0]  frac_out,
    input logic [63:0] table_bits,
    input logic [1:0]  mode_bits
);

    logic [5:0] idx_full;
    assign idx_full = {lut_in[5] | mode_bits[1], lut_in[4] | mode_bits[0], lut_in[3:0]};

    // R2, R4: the last chain position takes cfg_in on an enabled edge
    p_shift_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> mode_bits[0] == $past(cfg_in));

    // R3: a disabled chain keeps every stored bit
    p_hold_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> ($stable(table_bits) && $stable(mode_bits) && $stable(cfg_out)));

    // R5, R6: the tree output matches the forced index into the stored table
    p_full_lookup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> lut_out == table_bits[idx_full]);

    // R7: both mode bits set reduce the full output to sub-table 3
    p_split_reduce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && mode_bits == 2'b11) |-> lut_out == table_bits[{2'b11, lut_in[3:0]}]);

    // R8: exported taps come from sub-tables 0 and 2
    p_tap_export_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> (frac_out[0] == table_bits[{2'b00, lut_in[3:0]}] &&
                     frac_out[1] == table_bits[{2'b10, lut_in[3:0]}]));

endmodule

bind frac_lut6 frac_lut6_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_in     (cfg_in),
    .cfg_out    (cfg_out),
    .lut_in     (lut_in),
    .lut_out    (lut_out),
    .frac_out   (frac_out),
    .table_bits (table_q),
    .mode_bits  (mode_q)
);

// File: tb/frac_lut6_tb.sv
module frac_lut6_tb;

    logic       clk;
    logic       rst_n;
    logic       cfg_en;
    logic       cfg_in;
    logic       cfg_out;
    logic [5:0] lut_in;
    logic       lut_out;
    logic [1:0] frac_out;

    int checks;
    int failures;

    frac_lut6 u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_in   (cfg_in),
        .cfg_out  (cfg_out),
        .lut_in   (lut_in),
        .lut_out  (lut_out),
        .frac_out (frac_out)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // each entry: {table[63:0], mode[1:0]}
    localparam int NV = 10;
    localparam logic [65:0] VEC [NV] = '{
        {64'hAAAA_AAAA_AAAA_AAAA, 2'b00},
        {64'hFFFF_0000_FFFF_0000, 2'b00},
        {64'hFFFF_FFFF_0000_0000, 2'b00},
        {64'h8000_0000_0000_0001, 2'b00},
        {64'hFFFF_0000_FFFF_0000, 2'b01},
        {64'hFFFF_FFFF_0000_0000, 2'b10},
        {64'h8000_0000_0000_0001, 2'b11},
        {64'h0123_4567_89AB_CDEF, 2'b11},
        {64'hDEAD_BEEF_CAFE_F00D, 2'b01},
        {64'h5A5A_C3C3_0FF0_9669, 2'b10}
    };

    function automatic logic ref_full(input logic [63:0] t, input logic [1:0] m, input logic [5:0] x);
        return t[{x[5] | m[1], x[4] | m[0], x[3:0]}];
    endfunction

    function automatic logic [1:0] ref_frac(input logic [63:0] t, input logic [5:0] x);
        return {t[32 + x[3:0]], t[x[3:0]]};
    endfunction

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic load(input logic [63:0] t, input logic [1:0] m);
        logic [65:0] w;
        w = {t, m};
        for (int i = 65; i >= 0; i--) begin
            cfg_en = 1'b1;
            cfg_in = w[i];
            @(posedge clk);
            @(negedge clk);
        end
        cfg_en = 1'b0;
        cfg_in = 1'b0;
    endtask

    task automatic sweep(input logic [63:0] t, input logic [1:0] m, input string req);
        logic [1:0] ef;
        for (int p = 0; p < 64; p++) begin
            lut_in = 6'(p);
            #1;
            ef = ref_frac(t, lut_in);
            check1(req, lut_out, ref_full(t, m, lut_in));
            checks++;
            if (frac_out !== ef) begin
                failures++;
                $display("FAIL R8 frac_out actual=%b expected=%b in=%0d mode=%b", frac_out, ef, p, m);
            end
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] rt;
        logic [1:0]  rm;
        checks   = 0;
        failures = 0;
        rst_n    = 1'b0;
        cfg_en   = 1'b0;
        cfg_in   = 1'b0;
        lut_in   = 6'd0;
        repeat (3) @(negedge clk);

        // R1: reset state, chain all zeros
        check1("R1 cfg_out", cfg_out, 1'b0);
        sweep(64'd0, 2'b00, "R1 lut_out");
        rst_n = 1'b1;
        @(negedge clk);

        // vector table walk: R5 plain, R6 single forcing, R7 both forced, R8 taps, R9 low inputs
        for (int v = 0; v < NV; v++) begin
            load(VEC[v][65:2], VEC[v][1:0]);
            case (VEC[v][1:0])
                2'b00:   sweep(VEC[v][65:2], VEC[v][1:0], "R5 lut_out");
                2'b11:   sweep(VEC[v][65:2], VEC[v][1:0], "R7 lut_out");
                default: sweep(VEC[v][65:2], VEC[v][1:0], "R6 lut_out");
            endcase
        end

        // random tables in every mode (R5, R6, R7, R9)
        for (int r = 0; r < 8; r++) begin
            rt = {$urandom, $urandom};
            rm = 2'(r);
            load(rt, rm);
            sweep(rt, rm, "R9 lut_out");
        end

        // R4, R2: first bit in (table[63]) sits on cfg_out after 66 shifts
        rt = 64'h8000_0000_0000_0000 | 64'h4000_0000_0000_0000 ^ 64'h4000_0000_0000_0000;
        load(rt, 2'b00);
        check1("R2 cfg_out after 66 shifts", cfg_out, 1'b1);
        cfg_en = 1'b1;
        cfg_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cfg_en = 1'b0;
        check1("R2 cfg_out after one more shift", cfg_out, 1'b0);

        // R4: ordering, table[0] is the bit just before the mode bits
        load(64'h0000_0000_0000_0001, 2'b00);
        lut_in = 6'd0;
        #1;
        check1("R4 table[0] placement", lut_out, 1'b1);
        lut_in = 6'd1;
        #1;
        check1("R4 neighbour bit", lut_out, 1'b0);

        // R3: cfg_in toggles with cfg_en low, nothing changes
        rt = 64'hC0FF_EE00_1234_8765;
        load(rt, 2'b10);
        for (int c = 0; c < 20; c++) begin
            cfg_in = ~cfg_in;
            @(posedge clk);
            @(negedge clk);
        end
        check1("R3 cfg_out held", cfg_out, rt[63]);
        sweep(rt, 2'b10, "R3 lut_out held");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule